// File: doc/BRIEF.md
# Transfer Unit Parameter Search

This block works out how a stream of pixels is packed into fixed-size transfer units on a serial display link with one, two or four lanes. From the pixel clock, the bits per pixel, the lane count and the per-lane symbol rate, it first finds the ratio of payload rate to link rate. This ratio is a fixed-point value scaled by 100000. The block then tries unit sizes from 64 down to 32. For each size it fits the expected count of valid symbols per unit to a restricted integer-plus-fraction form. It keeps the size whose fitted value overshoots the true value the least.

The result is the chosen unit size, the integer valid-symbol count, a fraction denominator, a flag that selects the subtractive form of the fraction, and a watermark value. A controller places the inputs on the port and pulses `start`. Some thousands of cycles later `done` rises, and the results stay on the outputs until the next accepted start. All divisions go through one shared bit-serial divider, so the block contains no combinational divider.

Top module: `tu_param_search`

## Requirements
- R1: After reset, `done` and `fail` are 0 and every result output is 0.
- R2: The per-lane rate is floor(floor(pix_clk_khz × bits_pp / 8) / lanes), where `lane_cnt` is 1, 2 or 4 (any other code counts as 1 lane). The ratio is floor(rate × 100000 / link rate), with link rate 162000 when `fast_rate`=0 and 270000 when `fast_rate`=1.
- R3: For each size, the valid count is ratio × size. The integer part is the valid count / 100000 and the remainder is the rest. If the remainder is zero, the candidate has integer part minus one, denominator 1, add flag 0 and error 0.
- R4: If the remainder is at least 50000, the denominator is ceil(100000 / (100000 − remainder)). If that value is 15 or less, the add flag is 1 and the error is 100000 − floor(100000/den) − remainder. Otherwise the flag is 0, the denominator is 1 and the error is 100000 − remainder. If the remainder is between 1 and 49999, the flag is 0, the denominator is min(floor(100000/remainder), 15) and the error is floor(100000/den) − remainder.
- R5: Sizes are tried from 64 down to 32. A candidate replaces the best only if its error is strictly smaller, starting from a bound of 64 × 100000, so on a tie the larger size wins.
- R6: The search stops at the first candidate with zero error. A zero error at size 64 gives `done` within 400 cycles of `start`.
- R7: `wmark` = floor(floor((100000 − ratio) × size × ratio / 100000) / 100000) + 6, using the chosen size. This assumes ratio ≤ 100000.
- R8: Once `done` is 1, it and all outputs hold steady until a new `start`. The cycle after an accepted `start`, `done` is 0.
- R9: A `start` pulse that arrives while a search is running is ignored. The results are those of the first inputs.
- R10: `fail` is 1 only if no candidate was kept, which cannot happen for valid inputs. With `done` high, `vs_den` lies in 1..15, and `vs_add`=1 implies `vs_den` ≥ 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; inputs sampled in this cycle |
| pix_clk_khz | input | 20 | Pixel clock in kHz |
| bits_pp | input | 6 | Bits per pixel |
| lane_cnt | input | 3 | Active lanes: 1, 2 or 4 |
| fast_rate | input | 1 | 0: 162000 kHz per lane, 1: 270000 kHz per lane |
| done | output | 1 | Results valid |
| fail | output | 1 | No candidate kept |
| tu_size | output | 7 | Chosen transfer-unit size |
| vs_int | output | 7 | Integer valid-symbol count |
| vs_den | output | 4 | Fraction denominator |
| vs_add | output | 1 | Subtractive fraction form selected |
| wmark | output | 6 | Watermark value |

## Verification
A bad branch choice or a wrong fraction denominator in a single candidate alters the kept size, the integer part or the denominator. This shows at the ports as soon as `done` rises after that search. A divider that loses one quotient bit shifts the ratio, so every result of the run is wrong. A comparison that keeps ties, or misses the zero-error exit, changes `tu_size` or stretches the latency far past the early-exit bound. The held results are re-read long after completion to catch any state that keeps moving once the search has finished.

// File: rtl/tu_pkg.sv
// Shared constants and the controller state type for the transfer-unit search.
// Assumes: states fit a 4-bit encoding.
package tu_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_RATIO_W, S_TU, S_TU_W, S_F1, S_F1_W, S_F2, S_F2_W,
        S_EVAL, S_WM1, S_WM1_W, S_WM2, S_WM2_W, S_DONE
    } tu_state_t;
endpackage

// File: rtl/tu_seq_div.sv
// Restoring radix-2 divider, one quotient bit per cycle.
// Assumes: den is nonzero; operands are sampled on go; results valid with fin.
module tu_seq_div #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         fin
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q_r, r_r, d_r;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial, diff;

    // Shift the next dividend bit into the partial remainder.
    always_comb begin
        trial = {r_r, q_r[W-1]};
        diff  = trial - {1'b0, d_r};
    end

    // Iterate one bit per cycle and pulse fin on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0; r_r <= '0; d_r <= '0; cnt <= '0; run <= 1'b0; fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                q_r <= num; r_r <= '0; d_r <= den; cnt <= CW'(W); run <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, d_r}) begin
                    r_r <= diff[W-1:0];
                    q_r <= {q_r[W-2:0], 1'b1};
                end else begin
                    r_r <= trial[W-1:0];
                    q_r <= {q_r[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign quo = q_r;
    assign rem = r_r;
endmodule

// File: rtl/tu_rate_front.sv
// Forms the dividend and divisor of the payload-to-link ratio.
// Assumes: lane code 1, 2 or 4; other codes count as one lane.
module tu_rate_front #(
    parameter int CLK_W   = 20,
    parameter int BPP_W   = 6,
    parameter int W       = 48,
    parameter int SCALE   = 100000,
    parameter int RATE_LO = 162000,
    parameter int RATE_HI = 270000
) (
    input  logic [CLK_W-1:0] pix_clk_khz,
    input  logic [BPP_W-1:0] bits_pp,
    input  logic [2:0]       lane_cnt,
    input  logic             fast_rate,
    output logic [W-1:0]     num,
    output logic [W-1:0]     den
);
    localparam int PW = CLK_W + BPP_W;

    logic [PW-1:0] prod, bytes, per_lane;

    // Byte rate split across the active lanes, then scaled.
    always_comb begin
        prod  = PW'(pix_clk_khz) * PW'(bits_pp);
        bytes = prod >> 3;
        case (lane_cnt)
            3'd4:    per_lane = bytes >> 2;
            3'd2:    per_lane = bytes >> 1;
            default: per_lane = bytes;
        endcase
        num = W'(per_lane) * W'(SCALE);
        den = fast_rate ? W'(RATE_HI) : W'(RATE_LO);
    end
endmodule

// File: rtl/tu_frac_fit.sv
// Maps the first fraction division to a denominator and form.
// Assumes: q/r are scale/(scale-rem) when hi, else scale/rem.
module tu_frac_fit #(
    parameter int W       = 48,
    parameter int MAX_DEN = 15,
    parameter int DEN_W   = 4
) (
    input  logic             hi,
    input  logic [W-1:0]     q,
    input  logic [W-1:0]     r,
    output logic [DEN_W-1:0] den,
    output logic             add,
    output logic             whole
);
    logic [W-1:0] up;

    // Round up in the high branch, clamp in the low branch.
    always_comb begin
        up    = q + W'(r != '0);
        den   = DEN_W'(1);
        add   = 1'b0;
        whole = 1'b0;
        if (hi) begin
            if (up <= W'(MAX_DEN)) begin
                den = up[DEN_W-1:0];
                add = 1'b1;
            end else begin
                whole = 1'b1;
            end
        end else if (q > W'(MAX_DEN)) begin
            den = DEN_W'(MAX_DEN);
        end else begin
            den = q[DEN_W-1:0];
        end
    end
endmodule

// File: rtl/tu_param_search.sv
// Searches transfer-unit sizes MAX_TU..MIN_TU for the least-error fraction fit,
// then computes the watermark. Assumes ratio <= SCALE and nonzero inputs.
module tu_param_search #(
    parameter int CLK_W   = 20,
    parameter int BPP_W   = 6,
    parameter int DIV_W   = 48,
    parameter int SCALE   = 100000,
    parameter int RATE_LO = 162000,
    parameter int RATE_HI = 270000,
    parameter int MAX_TU  = 64,
    parameter int MIN_TU  = 32,
    parameter int MAX_DEN = 15,
    parameter int WM_BIAS = 6,
    parameter int WM_W    = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [CLK_W-1:0]                pix_clk_khz,
    input  logic [BPP_W-1:0]                bits_pp,
    input  logic [2:0]                      lane_cnt,
    input  logic                            fast_rate,
    output logic                            done,
    output logic                            fail,
    output logic [$clog2(MAX_TU+1)-1:0]     tu_size,
    output logic [$clog2(MAX_TU+1)-1:0]     vs_int,
    output logic [$clog2(MAX_DEN+1)-1:0]    vs_den,
    output logic                            vs_add,
    output logic [WM_W-1:0]                 wmark
);
    import tu_pkg::*;
    localparam int SZ_W  = $clog2(MAX_TU + 1);
    localparam int DEN_W = $clog2(MAX_DEN + 1);
    localparam int W     = DIV_W;

    tu_state_t        st;
    logic [W-1:0]     ratio_r, vi_r, remv_r, err_r, best_err;
    logic [SZ_W-1:0]  size_r, best_size, best_vi;
    logic [DEN_W-1:0] den_r, best_den, fit_den;
    logic             hi_r, add_r, best_add, fit_add, fit_whole;
    logic [WM_W-1:0]  wm_r;
    logic             done_r, fail_r, searching, better;
    logic             div_go, div_fin;
    logic [W-1:0]     div_num, div_den, div_quo, div_rem, fr_num, fr_den;

    tu_rate_front #(.CLK_W(CLK_W), .BPP_W(BPP_W), .W(W), .SCALE(SCALE),
                    .RATE_LO(RATE_LO), .RATE_HI(RATE_HI)) u_front (
        .pix_clk_khz(pix_clk_khz), .bits_pp(bits_pp), .lane_cnt(lane_cnt),
        .fast_rate(fast_rate), .num(fr_num), .den(fr_den));

    tu_seq_div #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
        .quo(div_quo), .rem(div_rem), .fin(div_fin));

    tu_frac_fit #(.W(W), .MAX_DEN(MAX_DEN), .DEN_W(DEN_W)) u_fit (
        .hi(hi_r), .q(div_quo), .r(div_rem), .den(fit_den), .add(fit_add),
        .whole(fit_whole));

    assign searching = !(st == S_IDLE || st == S_DONE);
    assign better    = err_r < best_err;

    // Select the operands of the shared divider for the current step.
    always_comb begin
        div_go  = 1'b0;
        div_num = '0;
        div_den = W'(SCALE);
        case (st)
            S_IDLE, S_DONE: begin
                div_go = start; div_num = fr_num; div_den = fr_den;
            end
            S_TU:  begin div_go = 1'b1; div_num = ratio_r * W'(size_r); end
            S_F1:  begin
                div_go = 1'b1; div_num = W'(SCALE);
                div_den = hi_r ? (W'(SCALE) - remv_r) : remv_r;
            end
            S_F2:  begin div_go = 1'b1; div_num = W'(SCALE); div_den = W'(den_r); end
            S_WM1: begin
                div_go = 1'b1;
                div_num = (W'(SCALE) - ratio_r) * W'(best_size) * ratio_r;
            end
            S_WM2: begin div_go = 1'b1; div_num = div_quo; end
            default: ;
        endcase
    end

    // Search controller: sequence divisions, fit, compare, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; ratio_r <= '0; vi_r <= '0; remv_r <= '0; err_r <= '0;
            best_err <= '0; size_r <= '0; best_size <= '0; best_vi <= '0;
            den_r <= '0; best_den <= '0; hi_r <= 1'b0; add_r <= 1'b0;
            best_add <= 1'b0; wm_r <= '0; done_r <= 1'b0; fail_r <= 1'b0;
        end else begin
            case (st)
                S_IDLE, S_DONE: if (start) begin
                    done_r <= 1'b0; fail_r <= 1'b0; best_size <= '0;
                    best_err <= W'(MAX_TU * SCALE); size_r <= SZ_W'(MAX_TU);
                    st <= S_RATIO_W;
                end
                S_RATIO_W: if (div_fin) begin ratio_r <= div_quo; st <= S_TU; end
                S_TU:  st <= S_TU_W;
                S_TU_W: if (div_fin) begin
                    vi_r <= div_quo; remv_r <= div_rem;
                    if (div_rem == '0) begin
                        vi_r <= div_quo - 1'b1; den_r <= DEN_W'(1);
                        add_r <= 1'b0; err_r <= '0; st <= S_EVAL;
                    end else begin
                        hi_r <= div_rem >= W'(SCALE / 2); st <= S_F1;
                    end
                end
                S_F1:  st <= S_F1_W;
                S_F1_W: if (div_fin) begin
                    den_r <= fit_den; add_r <= fit_add;
                    if (fit_whole) begin
                        err_r <= W'(SCALE) - remv_r; st <= S_EVAL;
                    end else begin
                        st <= S_F2;
                    end
                end
                S_F2:  st <= S_F2_W;
                S_F2_W: if (div_fin) begin
                    err_r <= (add_r ? (W'(SCALE) - div_quo) : div_quo) - remv_r;
                    st <= S_EVAL;
                end
                S_EVAL: begin
                    if (better) begin
                        best_err <= err_r; best_size <= size_r;
                        best_vi <= vi_r[SZ_W-1:0]; best_den <= den_r; best_add <= add_r;
                    end
                    if (better && err_r == '0) begin
                        st <= S_WM1;
                    end else if (size_r == SZ_W'(MIN_TU)) begin
                        if (better || best_size != '0) begin
                            st <= S_WM1;
                        end else begin
                            fail_r <= 1'b1; done_r <= 1'b1; st <= S_DONE;
                        end
                    end else begin
                        size_r <= size_r - 1'b1; st <= S_TU;
                    end
                end
                S_WM1:   st <= S_WM1_W;
                S_WM1_W: if (div_fin) st <= S_WM2;
                S_WM2:   st <= S_WM2_W;
                S_WM2_W: if (div_fin) begin
                    wm_r <= WM_W'(div_quo) + WM_W'(WM_BIAS);
                    done_r <= 1'b1; st <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign done    = done_r;
    assign fail    = fail_r;
    assign tu_size = best_size;
    assign vs_int  = best_vi;
    assign vs_den  = best_den;
    assign vs_add  = best_add;
    assign wmark   = wm_r;
endmodule

// File: rtl/tu_param_search_chk.sv
// Property checker for the transfer-unit search, bound to the top module.
// Assumes: searching is high from the cycle after an accepted start until done.
module tu_param_search_chk #(
    parameter int SZ_W  = 7,
    parameter int DEN_W = 4,
    parameter int WM_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             searching,
    input logic             done,
    input logic             fail,
    input logic [SZ_W-1:0]  tu_size,
    input logic [SZ_W-1:0]  vs_int,
    input logic [DEN_W-1:0] vs_den,
    input logic             vs_add,
    input logic [WM_W-1:0]  wmark
);
    a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(tu_size) && $stable(vs_int) &&
        $stable(vs_den) && $stable(vs_add) && $stable(wmark) && $stable(fail));

    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !searching && start |=> !done && searching);

    a_r9_no_done_mid_search: assert property (@(posedge clk) disable iff (!rst_n)
        searching |-> !done);

    a_r10_den_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> vs_den >= DEN_W'(1) && vs_den <= DEN_W'(15));

    a_r4_add_den: assert property (@(posedge clk) disable iff (!rst_n)
        done && vs_add |-> vs_den >= DEN_W'(2));

    a_r5_size_range: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fail |-> tu_size >= SZ_W'(32) && tu_size <= SZ_W'(64));

    a_r7_wm_floor: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fail |-> wmark >= WM_W'(6));

    a_r10_no_fail: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fail);
endmodule

bind tu_param_search tu_param_search_chk #(.SZ_W(SZ_W), .DEN_W(DEN_W), .WM_W(WM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .searching(searching),
    .done(done), .fail(fail), .tu_size(tu_size), .vs_int(vs_int),
    .vs_den(vs_den), .vs_add(vs_add), .wmark(wmark));

// File: tb/tb_tu_param_search.sv
module tb_tu_param_search;
    localparam int S  = 100000;
    localparam int NV = 12;
    // clk, bpp, lanes, fast, size, int, den, add, wm  (size -1: use model)
    localparam int TBL [NV][9] = '{
        '{162000,  8, 1, 0, 64, 63, 1, 0,  6},
        '{ 81000,  8, 1, 0, 64, 31, 1, 0, 22},
        '{270000, 24, 4, 1, 64, 47, 1, 0, 18},
        '{135000, 24, 2, 1, 64, 47, 1, 0, 18},
        '{300000, 18, 4, 1, 64, 39, 1, 0, 21},
        '{148500, 24, 4, 1, -1, 0, 0, 0, 0},
        '{ 65000, 24, 2, 1, -1, 0, 0, 0, 0},
        '{ 25175, 24, 1, 0, -1, 0, 0, 0, 0},
        '{154000, 24, 4, 1, -1, 0, 0, 0, 0},
        '{ 33000, 16, 1, 0, -1, 0, 0, 0, 0},
        '{148500, 18, 2, 1, -1, 0, 0, 0, 0},
        '{100000, 30, 4, 0, -1, 0, 0, 0, 0}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [19:0] pclk = '0;
    logic [5:0]  bpp = '0;
    logic [2:0]  lanes = 3'd1;
    logic        fast = 1'b0;
    logic        done, fail, vs_add;
    logic [6:0]  tu_size, vs_int;
    logic [3:0]  vs_den;
    logic [5:0]  wmark;
    int tests = 0, fails = 0, lat;

    always #2 clk = ~clk;

    tu_param_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_clk_khz(pclk),
        .bits_pp(bpp), .lane_cnt(lanes), .fast_rate(fast), .done(done),
        .fail(fail), .tu_size(tu_size), .vs_int(vs_int), .vs_den(vs_den),
        .vs_add(vs_add), .wmark(wmark));

    task automatic chk(string req, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Expected results from the requirement text (R2..R7).
    task automatic model(input longint c, b, l, f, output longint sz, vi, dn, ad, wm);
        longint rate, ratio, best, v, q, r, fd, a, e;
        rate  = (c * b / 8) / ((l == 4 || l == 2) ? l : 1);
        ratio = rate * S / (f ? 270000 : 162000);
        best = 64 * S; sz = 0; vi = 0; dn = 0; ad = 0;
        for (int t = 64; t >= 32; t--) begin
            v = ratio * t; q = v / S; r = v % S;
            if (r == 0) begin q = q - 1; fd = 1; a = 0; e = 0; end
            else if (r >= S / 2) begin
                fd = S / (S - r) + ((S % (S - r)) != 0 ? 1 : 0);
                if (fd <= 15) begin a = 1; e = S - S / fd - r; end
                else begin a = 0; fd = 1; e = S - r; end
            end else begin
                a = 0; fd = S / r; if (fd > 15) fd = 15; e = S / fd - r;
            end
            if (e < best) begin
                best = e; sz = t; vi = q % 128; dn = fd; ad = a;
                if (e == 0) break;
            end
        end
        wm = ((S - ratio) * sz * ratio) / S / S + 6;
    endtask

    task automatic launch(input int c, b, l, f);
        @(negedge clk);
        pclk = 20'(c); bpp = 6'(b); lanes = 3'(l); fast = f[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
    endtask

    task automatic wait_done();
        while (!done) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        longint sz, vi, dn, ad, wm;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 done", done, 0); chk("R1 fail", fail, 0);
        chk("R1 tu_size", tu_size, 0); chk("R1 vs_int", vs_int, 0);
        chk("R1 vs_den", vs_den, 0); chk("R1 vs_add", vs_add, 0); chk("R1 wmark", wmark, 0);

        for (int i = 0; i < NV; i++) begin
            launch(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3]);
            chk("R8 done cleared after start", done, 0);
            wait_done();
            if (TBL[i][4] >= 0) begin
                sz = TBL[i][4]; vi = TBL[i][5]; dn = TBL[i][6]; ad = TBL[i][7]; wm = TBL[i][8];
            end else begin
                model(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], sz, vi, dn, ad, wm);
            end
            chk("R5 tu_size", tu_size, sz);
            chk("R3 R4 vs_int", vs_int, vi);
            chk("R4 vs_den", vs_den, dn);
            chk("R4 vs_add", vs_add, ad);
            chk("R7 wmark", wmark, wm);
            chk("R10 fail", fail, 0);
            if (i == 0) chk("R6 early stop latency<400", (lat < 400) ? 1 : 0, 1);
        end

        // R8: results hold after done
        launch(81000, 8, 1, 0);
        wait_done();
        repeat (60) @(negedge clk);
        chk("R8 done held", done, 1);
        chk("R8 tu_size held", tu_size, 64);
        chk("R8 vs_int held", vs_int, 31);
        chk("R8 wmark held", wmark, 22);

        // R9: a start during a search is ignored
        launch(162000, 8, 1, 0);
        repeat (60) @(negedge clk);
        pclk = 20'd270000; bpp = 6'd24; lanes = 3'd4; fast = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R9 vs_int from first inputs", vs_int, 63);
        chk("R9 wmark from first inputs", wmark, 6);

        // R2: lane code outside 1/2/4 counts as one lane
        launch(162000, 8, 3, 0);
        wait_done();
        chk("R2 odd lane code vs_int", vs_int, 63);

        finish_run();
    end
endmodule